// File: doc/BRIEF.md
# Scanned Keyboard Matrix Controller

This block reads a key matrix of up to 64 switches. It steps through the rows on four scan outputs and samples eight column inputs on each row. Once a key has been confirmed as pressed, its position and the state of two modifier inputs go into an eight-entry queue. An interrupt output stays high while the queue holds anything. A host reads the queue one byte at a time. The host also sets the scan style, the key acceptance policy and the row dwell time.

The scan outputs run in one of two styles. In the one-hot style, four rows are driven directly. In the binary style, the row number goes out for an external decoder, which gives eight rows. A key counts as pressed only when it reads closed on two consecutive visits to its row. Under the single-key policy, one confirmed key blocks all others until it is released. Under the rollover policy, every confirmed key is queued.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: After reset, the irq output is 0 and scan_out is 4'b0001. A status read returns 0x00 and a data read returns 0x00. The mode is one-hot scan with the single-key policy, and the dwell is DIV_RST+1 clocks.
- R2: With mode bit0 = 0, scan_out steps through 0001, 0010, 0100, 1000 and then wraps. Each value holds for one dwell.
- R3: With mode bit0 = 1, scan_out presents the row number 0 to 7 in binary, with bit 3 held at 0. Each value holds for one dwell and the count wraps after 7.
- R4: A key is queued only when its column input is high on two consecutive visits to its row. A key seen on one visit only is not queued. A key that stays closed is queued once, and is queued again only after it reads open and is then confirmed anew.
- R5: A queue entry is {ctrl_in, shift_in, row[2:0], column[2:0]}, from bit 7 down to bit 0. The modifier inputs are taken at the moment of queuing.
- R6: With mode bit1 = 0, no other key is queued while a queued key still reads closed. If two keys are confirmed in the same pass, the earlier one in scan order wins, meaning the lower row and then the lower column. A blocked key that is still held is queued after the winner is released.
- R7: With mode bit1 = 1, every confirmed key is queued, in the order the rows are scanned and in ascending column order within a row.
- R8: A read with host_a0 = 0 returns the oldest entry and removes it. On an empty queue it returns 0x00 and changes nothing.
- R9: irq is high exactly while the queue holds at least one entry. It falls on the clock after the last entry is read.
- R10: The queue holds 8 entries. A key confirmed while the queue is full is dropped and sets the overrun flag. A read with host_a0 = 1 returns {overrun, 3'b000, count[3:0]}.
- R11: A write with host_a0 = 1 and bit7 = 1 sets the dwell to bits[6:0]+1 clocks, and a value of 0 acts as 1.
- R12: A write with host_a0 = 1 and bit7 = 0 loads the mode from bit0 (binary scan) and bit1 (rollover). It clears the overrun flag, restarts the scan at row 0 and forgets all key history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_a0 | input | 1 | 0 selects queue data, 1 selects command or status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| irq | output | 1 | High while the queue is not empty |
| scan_out | output | 4 | Row drive, one-hot or binary |
| ret_in | input | 8 | Column inputs, high means the key is closed |
| shift_in | input | 1 | Shift modifier state |
| ctrl_in | input | 1 | Control modifier state |

## Verification
The hardest states to reach are overrun and a press that lasts exactly one row visit, because both depend on where the scan is when a key changes. The stimulus restarts the scan with a mode write before each multi-key test, which pins down the scan order. It holds a full row plus two more keys under the rollover policy to push past eight entries. For the debounce case, it watches scan_out until the target row appears and releases the key as soon as the scan leaves that row.

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl #(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_RST    = 99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_a0,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  output logic [3:0] scan_out,
  input  logic [7:0] ret_in,
  input  logic       shift_in,
  input  logic       ctrl_in
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;
  localparam int DW = 7;

  logic [DW-1:0] div_val, pcnt;
  logic          enc_mode, nkro_mode, overrun;
  logic [2:0]    row;
  logic [7:0]    ret_q;
  logic [63:0]   prev_map, held_map;
  logic [7:0]    fifo_mem [FIFO_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [2:0]    col;
  logic          found;

  wire cmd_wr  = host_cs & host_wr & host_a0;
  wire mode_wr = cmd_wr & ~host_wdata[7];
  wire div_wr  = cmd_wr & host_wdata[7];
  wire tick    = (pcnt >= div_val);
  wire [2:0] last_row = enc_mode ? 3'd7 : 3'd3;
  wire [5:0] base = {row, 3'b000};
  wire [7:0] prev_row = prev_map[base +: 8];
  wire [7:0] held_row = held_map[base +: 8];
  wire [7:0] cand = ret_q & prev_row & ~held_row;
  wire allow  = nkro_mode | ~|held_map;
  wire accept = (pcnt != '0) & found & allow & ~mode_wr;
  wire full   = (count == CW'(FIFO_DEPTH));
  wire empty  = (count == '0);
  wire pop    = host_cs & host_rd & ~host_a0 & ~empty;
  wire push   = accept & ~full;
  wire [7:0] held_next = (tick ? (held_row & ret_q) : held_row) | (accept ? (8'd1 << col) : 8'd0);

  always_comb begin
    found = 1'b0;
    col = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        col = 3'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val   <= DW'(DIV_RST < 1 ? 1 : DIV_RST);
      enc_mode  <= 1'b0;
      nkro_mode <= 1'b0;
      pcnt      <= '0;
      row       <= '0;
      ret_q     <= '0;
    end else begin
      ret_q <= ret_in;
      if (div_wr) div_val <= (host_wdata[6:0] == 7'd0) ? DW'(1) : host_wdata[6:0];
      if (mode_wr) begin
        enc_mode  <= host_wdata[0];
        nkro_mode <= host_wdata[1];
        pcnt      <= '0;
        row       <= '0;
      end else if (tick) begin
        pcnt <= '0;
        row  <= (row == last_row) ? 3'd0 : row + 3'd1;
      end else begin
        pcnt <= pcnt + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_map <= '0;
      held_map <= '0;
    end else if (mode_wr) begin
      prev_map <= '0;
      held_map <= '0;
    end else begin
      if (tick) prev_map[base +: 8] <= ret_q;
      if (tick || accept) held_map[base +: 8] <= held_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) begin
        fifo_mem[wp] <= {ctrl_in, shift_in, row, col};
        wp <= wp + PW'(1);
      end
      if (pop) rp <= rp + PW'(1);
      count <= count + CW'(push) - CW'(pop);
      if (mode_wr) overrun <= 1'b0;
      else if (accept && full) overrun <= 1'b1;
    end
  end

  assign scan_out   = enc_mode ? {1'b0, row} : (4'b0001 << row[1:0]);
  assign irq        = ~empty;
  assign host_rdata = host_a0 ? ({overrun, 7'd0} | 8'(count)) : (empty ? 8'd0 : fifo_mem[rp]);

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(FIFO_DEPTH));
  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (accept && full) |=> overrun);
  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push) |=> (count == $past(count) - CW'(1)));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push && count == CW'(1)) |=> !irq);
  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) !enc_mode |-> ($countones(scan_out) == 1));
  // R3
  enc_top_chk: assert property (@(posedge clk) disable iff (!rst_n) enc_mode |-> !scan_out[3]);
  // R6
  lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n) (!nkro_mode && accept) |=> !accept);
endmodule

// File: tb/test_kbd_scan_ctrl.sv
module test_kbd_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SCAN = 64;
  localparam int NV = 6;
  // {mode[1:0], ctrl, shift, row[2:0], col[2:0], expected[7:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b0, 3'd7, 3'd7, 8'hBF},
    {2'b00, 1'b0, 1'b1, 3'd3, 3'd0, 8'h58},
    {2'b01, 1'b0, 1'b0, 3'd5, 3'd2, 8'h2A},
    {2'b11, 1'b1, 1'b1, 3'd6, 3'd4, 8'hF4},
    {2'b10, 1'b0, 1'b1, 3'd0, 3'd0, 8'h40},
    {2'b00, 1'b1, 1'b0, 3'd2, 3'd5, 8'h95}
  };

  logic clk = 0, rst_n = 0;
  logic host_cs = 0, host_wr = 0, host_rd = 0, host_a0 = 0;
  logic [7:0] host_wdata = 0, host_rdata, ret_in;
  logic irq, shift_in = 0, ctrl_in = 0;
  logic [3:0] scan_out;
  logic [63:0] keymat = '0;
  logic enc_b = 0;
  int checks = 0, fails = 0;
  logic [2:0] brow;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign brow = enc_b ? scan_out[2:0] : {1'b0, scan_out[3] | scan_out[2], scan_out[3] | scan_out[1]};
  assign ret_in = keymat[{brow, 3'b000} +: 8];

  kbd_scan_ctrl i_kbd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_a0(host_a0), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .scan_out(scan_out), .ret_in(ret_in), .shift_in(shift_in), .ctrl_in(ctrl_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic a0, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_a0 = a0; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_wr = 0;
  endtask

  task automatic hread(input logic a0, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_a0 = a0;
    #1 d = host_rdata;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    enc_b = m[0];
    hwrite(1'b1, {6'd0, m});
  endtask

  task automatic key(input int r, input int c, input logic v);
    keymat[r*8 + c] = v;
  endtask

  task automatic wait_scans(input int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic measure_dwell(output int n);
    logic [3:0] s;
    @(negedge clk); s = scan_out;
    while (scan_out == s) @(negedge clk);
    s = scan_out; n = 0;
    while (scan_out == s) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    hread(1'b1, d); chk("R1 status", d, 8'h00);
    hread(1'b0, d); chk("R1 data", d, 8'h00);
    measure_dwell(n); chk("R1 default dwell", 8'(n), 8'(100));

    // R11 divisor
    hwrite(1'b1, 8'h80);
    measure_dwell(n); measure_dwell(n); chk("R11 zero divisor", 8'(n), 8'd2);
    hwrite(1'b1, 8'h87);
    measure_dwell(n); measure_dwell(n); chk("R11 divisor 7", 8'(n), 8'd8);

    // R12 restart and R2 one-hot sequence
    set_mode(2'b00);
    chk("R12 row0 after mode write", {4'd0, scan_out}, 8'h01);
    for (int i = 1; i <= 4; i++) begin
      logic [3:0] s;
      s = scan_out;
      while (scan_out == s) @(negedge clk);
      chk("R2 one-hot step", {4'd0, scan_out}, 8'(4'b0001 << (i % 4)));
    end

    // R3 binary sequence
    set_mode(2'b01);
    chk("R12 row0 binary", {4'd0, scan_out}, 8'h00);
    for (int i = 1; i <= 8; i++) begin
      logic [3:0] s;
      s = scan_out;
      while (scan_out == s) @(negedge clk);
      chk("R3 binary step", {4'd0, scan_out}, 8'(i % 8));
    end

    // R5 R8 R9 table of single keys
    for (int v = 0; v < NV; v++) begin
      set_mode(VEC[v][17:16]);
      ctrl_in = VEC[v][15]; shift_in = VEC[v][14];
      key(VEC[v][13:11], VEC[v][10:8], 1'b1);
      wait_scans(4);
      chk("R9 irq with entry", {7'd0, irq}, 8'h01);
      hread(1'b1, d); chk("R10 status count one", d, 8'h01);
      hread(1'b0, d); chk("R5 entry layout", d, VEC[v][7:0]);
      @(negedge clk);
      chk("R9 irq after drain", {7'd0, irq}, 8'h00);
      key(VEC[v][13:11], VEC[v][10:8], 1'b0);
      wait_scans(2);
      hread(1'b1, d); chk("R4 held key queued once", d, 8'h00);
    end
    ctrl_in = 0; shift_in = 0;

    // R4 one-visit press
    set_mode(2'b00);
    while (scan_out != 4'b0100) @(negedge clk);
    key(2, 4, 1'b1);
    while (scan_out == 4'b0100) @(negedge clk);
    key(2, 4, 1'b0);
    wait_scans(4);
    hread(1'b1, d); chk("R4 single-visit ignored", d, 8'h00);

    // R6 lockout
    set_mode(2'b00);
    key(1, 2, 1'b1); key(2, 5, 1'b1);
    wait_scans(4);
    hread(1'b1, d); chk("R6 only one queued", d, 8'h01);
    hread(1'b0, d); chk("R6 earlier key wins", d, 8'h0A);
    key(1, 2, 1'b0);
    wait_scans(4);
    hread(1'b1, d); chk("R6 blocked key after release", d, 8'h01);
    hread(1'b0, d); chk("R6 blocked key code", d, 8'h15);
    key(2, 5, 1'b0);
    wait_scans(2);

    // R7 rollover order
    set_mode(2'b10);
    key(0, 6, 1'b1); key(0, 1, 1'b1); key(2, 3, 1'b1);
    wait_scans(4);
    hread(1'b1, d); chk("R7 three queued", d, 8'h03);
    hread(1'b0, d); chk("R7 first", d, 8'h01);
    hread(1'b0, d); chk("R7 second", d, 8'h06);
    hread(1'b0, d); chk("R7 third", d, 8'h13);
    keymat = '0;
    wait_scans(2);

    // R10 overflow
    set_mode(2'b11);
    for (int c = 0; c < 8; c++) key(3, c, 1'b1);
    key(5, 0, 1'b1); key(5, 1, 1'b1);
    wait_scans(6);
    hread(1'b1, d); chk("R10 full with overrun", d, 8'h88);
    hread(1'b0, d); chk("R10 head entry", d, 8'h18);
    for (int i = 1; i < 8; i++) hread(1'b0, d);
    @(negedge clk);
    chk("R9 irq low when empty", {7'd0, irq}, 8'h00);
    hread(1'b0, d); chk("R8 empty read", d, 8'h00);
    hread(1'b1, d); chk("R8 empty read no change", d, 8'h80);
    keymat = '0;
    wait_scans(2);
    set_mode(2'b00);
    hread(1'b1, d); chk("R12 overrun cleared", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule